// File: doc/BRIEF.md
# Three-Phase Over-Threshold Event Detector

This block watches three signed phase sample streams, one each for phases A, B and C, and raises an event when the magnitude of any sample strictly exceeds a programmable 24-bit unsigned limit. An event sets a sticky summary flag in a status word and sticky per-phase flags in a separate, read-only phase word, so software can tell which phases crossed the limit. An active-low interrupt follows the summary flag whenever the matching mask bit is set.

Software services an event in three steps. It reads the status word, then reads the phase word to find the offending phases. It then writes the status word with the summary bit at one. That single write clears the summary flag and every phase flag, and it releases the interrupt. One instance serves one measurement channel. A second instance can watch the other channel against its own limit.

Top module: `ovt_detector`

## Requirements
- R1: After reset, `stat_rd` and `phase_rd` are all zero and `irq_n` is 1.
- R2: A sample whose valid strobe is high at a rising edge, with a magnitude strictly greater than `limit`, sets `stat_rd[18]` to 1, visible after that same edge.
- R3: A sample whose magnitude equals `limit` causes no event. A sample whose valid strobe is low causes no event, whatever its value.
- R4: An event on phase A sets `phase_rd[9]`, phase B sets `phase_rd[10]`, and phase C sets `phase_rd[11]`. Several phase bits may be set at once, and all other bits of `phase_rd` read as zero.
- R5: All flags are sticky. They stay set after later samples fall back to or below `limit`.
- R6: `irq_n` is 0 exactly when `stat_rd[18]` is 1 and `mask[18]` is 1; otherwise it is 1.
- R7: A cycle with `wr_en` high and `wr_data[18]` at 1 clears `stat_rd[18]` and `phase_rd[11:9]` after that edge, which returns `irq_n` to 1.
- R8: A write with `wr_data[18]` at 0 leaves every flag unchanged.
- R9: If an event occurs in the same cycle as a clearing write, the clear is ignored. All flags that were already set stay set, and the new phase flag is added.
- R10: The magnitude is the two's-complement absolute value. This includes the most negative sample, -8388608, whose magnitude is 8388608.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_smp | input | 24 | Phase A signed sample |
| a_vld | input | 1 | Phase A sample strobe |
| b_smp | input | 24 | Phase B signed sample |
| b_vld | input | 1 | Phase B sample strobe |
| c_smp | input | 24 | Phase C signed sample |
| c_vld | input | 1 | Phase C sample strobe |
| limit | input | 24 | Unsigned magnitude threshold |
| mask | input | 32 | Interrupt enable word; bit 18 gates the event |
| wr_en | input | 1 | Status word write strobe |
| wr_data | input | 32 | Status write data; bit 18 at 1 clears the flags |
| stat_rd | output | 32 | Status word; bit 18 is the summary event flag |
| phase_rd | output | 32 | Phase word; bits 11:9 flag phases C, B and A |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Several properties are checked on every cycle:
- any comparator hit sets the summary flag on the following cycle;
- flags persist when no clearing write arrives;
- a clearing write without a hit empties both words;
- phase flags never appear without the summary flag;
- a cleared mask bit keeps the interrupt high.

Other behaviour can only be shown by the bench's scenarios, because it depends on particular sample values. This covers the strict comparison at equality, the magnitude of the most negative sample, the mapping of each phase to its bit, and the priority of an event over a clear in the same cycle.

// File: rtl/ovt_pkg.sv
package ovt_pkg;
  localparam int SMP_W    = 24;
  localparam int NUM_PH   = 3;
  localparam int REG_W    = 32;
  localparam int EVT_BIT  = 18;
  localparam int PH_LSB   = 9;
  localparam int PH_MSB   = PH_LSB + NUM_PH - 1;
endpackage

// File: rtl/ovt_mag_cmp.sv
module ovt_mag_cmp #(
  parameter int SMP_W = 24
) (
  input  logic signed [SMP_W-1:0] smp,
  input  logic                    vld,
  input  logic        [SMP_W-1:0] limit,
  output logic                    hit
);
  logic [SMP_W-1:0] mag;

  // two's-complement magnitude; the most negative code maps to 2^(SMP_W-1)
  always_comb begin
    if (smp[SMP_W-1]) mag = ~smp + 1'b1;
    else              mag = smp;
    hit = vld && (mag > limit);
  end
endmodule

// File: rtl/ovt_flag_reg.sv
module ovt_flag_reg #(
  parameter int NUM_PH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PH-1:0] hit,
  input  logic              clr,
  output logic              evt_q,
  output logic [NUM_PH-1:0] ph_q
);
  logic              any_hit;
  logic              upd_en;
  logic              evt_d;
  logic [NUM_PH-1:0] ph_d;

  always_comb begin
    any_hit = |hit;
    upd_en  = any_hit || clr;
    if (any_hit) begin
      // a new event outranks a coincident clear
      evt_d = 1'b1;
      ph_d  = ph_q | hit;
    end else begin
      evt_d = 1'b0;
      ph_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
      ph_q  <= '0;
    end else if (upd_en) begin
      evt_q <= evt_d;
      ph_q  <= ph_d;
    end
  end
endmodule

// File: rtl/ovt_detector.sv
module ovt_detector
  import ovt_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [SMP_W-1:0] a_smp,
  input  logic                    a_vld,
  input  logic signed [SMP_W-1:0] b_smp,
  input  logic                    b_vld,
  input  logic signed [SMP_W-1:0] c_smp,
  input  logic                    c_vld,
  input  logic        [SMP_W-1:0] limit,
  input  logic        [REG_W-1:0] mask,
  input  logic                    wr_en,
  input  logic        [REG_W-1:0] wr_data,
  output logic        [REG_W-1:0] stat_rd,
  output logic        [REG_W-1:0] phase_rd,
  output logic                    irq_n
);
  logic signed [SMP_W-1:0] smp_arr [NUM_PH];
  logic        [NUM_PH-1:0] vld_vec;
  logic        [NUM_PH-1:0] hit_vec;
  logic                     clr_req;
  logic                     evt_q;
  logic        [NUM_PH-1:0] ph_q;

  always_comb begin
    smp_arr[0] = a_smp;
    smp_arr[1] = b_smp;
    smp_arr[2] = c_smp;
    vld_vec    = {c_vld, b_vld, a_vld};
  end

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    ovt_mag_cmp #(.SMP_W(SMP_W)) i_cmp (
      .smp   (smp_arr[p]),
      .vld   (vld_vec[p]),
      .limit (limit),
      .hit   (hit_vec[p])
    );
  end

  assign clr_req = wr_en && wr_data[EVT_BIT];

  ovt_flag_reg #(.NUM_PH(NUM_PH)) i_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit_vec),
    .clr   (clr_req),
    .evt_q (evt_q),
    .ph_q  (ph_q)
  );

  always_comb begin
    stat_rd                  = '0;
    stat_rd[EVT_BIT]         = evt_q;
    phase_rd                 = '0;
    phase_rd[PH_MSB:PH_LSB]  = ph_q;
    irq_n                    = !(evt_q && mask[EVT_BIT]);
  end
endmodule

module ovt_detector_chk
  import ovt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_PH-1:0] hit_vec,
  input logic              clr_req,
  input logic [REG_W-1:0]  stat_rd,
  input logic [REG_W-1:0]  phase_rd,
  input logic [REG_W-1:0]  mask,
  input logic              irq_n
);
  AST_HIT_SETS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |=> stat_rd[EVT_BIT]); // R2
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd[EVT_BIT] && !clr_req) |=> stat_rd[EVT_BIT]); // R5
  AST_PH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_req |=> ((phase_rd & $past(phase_rd)) == $past(phase_rd))); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !(|hit_vec)) |=> (!stat_rd[EVT_BIT] && phase_rd == '0)); // R7
  AST_PH_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_rd != '0) |-> stat_rd[EVT_BIT]); // R4
  AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mask[EVT_BIT] |-> irq_n); // R6
  AST_COINCIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && (|hit_vec)) |=> stat_rd[EVT_BIT]); // R9
endmodule

bind ovt_detector ovt_detector_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hit_vec  (hit_vec),
  .clr_req  (clr_req),
  .stat_rd  (stat_rd),
  .phase_rd (phase_rd),
  .mask     (mask),
  .irq_n    (irq_n)
);

// File: tb/test_ovt_detector.sv
module test_ovt_detector;
  logic               clk;
  logic               rst_n;
  logic signed [23:0] a_smp, b_smp, c_smp;
  logic               a_vld, b_vld, c_vld;
  logic        [23:0] limit;
  logic        [31:0] mask;
  logic               wr_en;
  logic        [31:0] wr_data;
  logic        [31:0] stat_rd;
  logic        [31:0] phase_rd;
  logic               irq_n;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  ovt_detector i_ovt_detector (
    .clk(clk), .rst_n(rst_n),
    .a_smp(a_smp), .a_vld(a_vld), .b_smp(b_smp), .b_vld(b_vld),
    .c_smp(c_smp), .c_vld(c_vld), .limit(limit), .mask(mask),
    .wr_en(wr_en), .wr_data(wr_data),
    .stat_rd(stat_rd), .phase_rd(phase_rd), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [31:0] EVT = 32'h0004_0000;
  localparam logic [31:0] PA  = 32'h0000_0200;
  localparam logic [31:0] PB  = 32'h0000_0400;
  localparam logic [31:0] PC  = 32'h0000_0800;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [31:0] st, input logic [31:0] ph, input logic irq);
    chk(req, stat_rd, st);
    chk(req, phase_rd, ph);
    chk(req, {31'd0, irq_n}, {31'd0, irq});
  endtask

  // one active cycle, then idle; outputs reflect that edge on return
  task automatic cyc(input logic signed [23:0] a, input logic signed [23:0] b,
                     input logic signed [23:0] c, input logic [2:0] v,
                     input logic w, input logic [31:0] wd);
    @(negedge clk);
    a_smp = a; b_smp = b; c_smp = c;
    {c_vld, b_vld, a_vld} = v;
    wr_en = w; wr_data = wd;
    @(negedge clk);
    {c_vld, b_vld, a_vld} = 3'b000;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic clear_all();
    cyc(0, 0, 0, 3'b000, 1'b1, EVT);
  endtask

  task automatic t_reset();
    chk_all("R1", 32'd0, 32'd0, 1'b1);
  endtask

  task automatic t_pos_event();
    cyc(24'sd1001, 0, 0, 3'b001, 1'b0, '0);
    chk_all("R2", EVT, PA, 1'b0);
    clear_all();
  endtask

  task automatic t_equal_and_invalid();
    cyc(24'sd1000, -24'sd1000, 0, 3'b011, 1'b0, '0);
    chk("R3 equal", stat_rd, 32'd0);
    cyc(24'sd5000, 24'sd5000, 24'sd5000, 3'b000, 1'b0, '0);
    chk("R3 invalid", stat_rd | phase_rd, 32'd0);
  endtask

  task automatic t_phase_map();
    cyc(0, 24'sd2000, 0, 3'b010, 1'b0, '0);
    chk("R4 B", phase_rd, PB);
    clear_all();
    cyc(24'sd3000, 0, -24'sd3000, 3'b101, 1'b0, '0);
    chk("R4 A+C", phase_rd, PA | PC);
    clear_all();
  endtask

  task automatic t_sticky();
    cyc(0, 0, 24'sd1500, 3'b100, 1'b0, '0);
    cyc(24'sd10, 24'sd10, 24'sd10, 3'b111, 1'b0, '0);
    cyc(0, 0, 0, 3'b000, 1'b0, '0);
    chk_all("R5", EVT, PC, 1'b0);
    clear_all();
  endtask

  task automatic t_mask();
    mask = 32'h0;
    cyc(24'sd1500, 0, 0, 3'b001, 1'b0, '0);
    chk("R6 masked", {31'd0, irq_n}, 32'd1);
    chk("R6 flag kept", stat_rd, EVT);
    mask = EVT;
    #1;
    chk("R6 unmasked", {31'd0, irq_n}, 32'd0);
    mask = ~EVT;
    #1;
    chk("R6 other bits", {31'd0, irq_n}, 32'd1);
    mask = EVT;
    clear_all();
  endtask

  task automatic t_clear();
    cyc(24'sd1500, 24'sd1500, 0, 3'b011, 1'b0, '0);
    clear_all();
    chk_all("R7", 32'd0, 32'd0, 1'b1);
  endtask

  task automatic t_write_zero();
    cyc(0, 24'sd1500, 0, 3'b010, 1'b0, '0);
    cyc(0, 0, 0, 3'b000, 1'b1, ~EVT);
    chk_all("R8", EVT, PB, 1'b0);
    clear_all();
  endtask

  task automatic t_coincide();
    cyc(24'sd1500, 0, 0, 3'b001, 1'b0, '0);
    cyc(0, 0, 24'sd1500, 3'b100, 1'b1, EVT);
    chk_all("R9", EVT, PA | PC, 1'b0);
    clear_all();
  endtask

  task automatic t_negative();
    limit = 24'h7F_FFFF;
    cyc(-24'sd8388607, 0, 0, 3'b001, 1'b0, '0);
    chk("R10 -max+1", stat_rd, 32'd0);
    cyc(0, -24'sd8388608, 0, 3'b010, 1'b0, '0);
    chk("R10 most negative", phase_rd, PB);
    clear_all();
    limit = 24'd1000;
    cyc(0, 0, -24'sd1001, 3'b100, 1'b0, '0);
    chk("R10 neg", phase_rd, PC);
    clear_all();
  endtask

  initial begin
    rst_n = 1'b0;
    a_smp = 0; b_smp = 0; c_smp = 0;
    a_vld = 0; b_vld = 0; c_vld = 0;
    limit = 24'd1000; mask = EVT;
    wr_en = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pos_event();
    t_equal_and_invalid();
    t_phase_map();
    t_sticky();
    t_mask();
    t_clear();
    t_write_zero();
    t_coincide();
    t_negative();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule